// File: doc/BRIEF.md
# Shared SPI Host for On-Board Peripherals

This block is one SPI host shared by six peripheral devices on a board: an output DAC, a clock distribution chip and four bias DACs. A requester presents a device code, a 16-bit address and 16-bit write data as steady levels. It then raises either the read control or the write control. The block turns a rising edge on either control into one serial frame. It pulls exactly one chip select low, shifts the frame out MSB first in SPI mode 0, and for reads captures an 8-bit reply.

The `idle` output tells the requester when a new access may begin. Edges that arrive while a frame is running are dropped, not queued. A device code that maps to no peripheral completes at once without touching the bus. All controls, indicators and the serial lines belong to one clock domain. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `spi_multidev_host`

## Requirements
- R1: During and after reset, `idle` is 1, every `cs_n` bit is 1, `sclk` is 0 and `rdata` is 0.
- R2: Device code k (1 to 6) drives `cs_n[k-1]` low, and only that bit, for the whole frame. No two chip selects are ever low together, and the chip select does not change during a frame.
- R3: An access starts only on a 0-to-1 transition of `rd_req` or `wr_req`. A control held high after its frame ends starts nothing further.
- R4: A write frame is 32 bits, sent MSB first on `mosi`: `addr[15:0]` followed by `wdata[15:0]`. `idle` stays low for exactly 32*CLK_DIV cycles.
- R5: A read frame sends a 1 flag bit and then `addr[14:0]`, MSB first, and then clocks in 8 bits from `miso`, first bit into bit 7. `idle` stays low for exactly 24*CLK_DIV cycles. The captured byte appears on `rdata` in the same cycle that `idle` returns to 1.
- R6: SPI mode 0 is used. `sclk` is 0 whenever no frame runs. Each bit lasts CLK_DIV cycles: `sclk` is low for the first half and high for the second. `miso` is sampled at the rising edge of `sclk`.
- R7: `idle` goes low in the cycle after an accepted edge and stays low until the frame ends. `cs_n` is all ones whenever `idle` is 1. A read or write edge that occurs while `idle` is 0 is ignored and does not start a later frame.
- R8: A strobe with device code 0 or 7 to 255 starts no frame. `idle` stays 1, no chip select falls, and `rdata` keeps its value.
- R9: If read and write edges arrive in the same cycle, only the write frame runs and `rdata` is unchanged.
- R10: A write frame leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, shared by all controls |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 8 | Target device code (1 to 6 valid) |
| addr | input | 16 | Register address for the access |
| wdata | input | 16 | Data sent by a write frame |
| rd_req | input | 1 | Read control; a rising edge starts a read |
| wr_req | input | 1 | Write control; a rising edge starts a write |
| rdata | output | 8 | Byte captured by the last read |
| idle | output | 1 | 1 when no frame is in progress |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |
| cs_n | output | 6 | Active-low chip selects, one per device |

## Verification
The bench builds the block with `CLK_DIV` at 4 and six chip selects. A divide ratio of 4 separates the miso sampling cycle from the cycle where the bit ends, so an off-by-one in either shows up on `sclk`, `mosi` or the captured byte. A pseudo-random `miso` stream, together with reads where `miso` is held at all ones or all zeros, shows which bit lands where in `rdata`. Every device code, several invalid codes, simultaneous edges, an edge raised in mid-frame and a held control are driven in turn against the reference model.

// File: rtl/spi_multidev_host.sv
module spi_multidev_host #(
  parameter int CLK_DIV = 4,
  parameter int NUM_CS  = 6,
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int RW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        dev_sel,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic [RW-1:0]     rdata,
  output logic              idle,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int SW      = AW + DW;
  localparam int RD_BITS = AW + RW;
  localparam int HALF    = CLK_DIV / 2;
  localparam int PW      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW      = $clog2(SW + 1);
  localparam logic [PW-1:0] PH_SAMPLE = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(CLK_DIV - 1);
  localparam logic [PW-1:0] PH_HALF   = PW'(HALF);
  localparam logic [7:0]    MAX_CODE  = 8'(NUM_CS);

  logic          busy, is_read;
  logic          rd_q, wr_q;
  logic [PW-1:0] phase;
  logic [BW-1:0] bits_left;
  logic [SW-1:0] shreg;
  logic [RW-1:0] rx;

  wire rd_edge = rd_req & ~rd_q;
  wire wr_edge = wr_req & ~wr_q;
  wire code_ok = (dev_sel != 8'd0) && (dev_sel <= MAX_CODE);
  wire start   = ~busy & (rd_edge | wr_edge) & code_ok;
  wire bit_end = busy && (phase == PH_LAST);

  assign idle = ~busy;
  assign sclk = busy && (phase >= PH_HALF);
  assign mosi = shreg[SW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      busy      <= 1'b0;
      is_read   <= 1'b0;
      phase     <= '0;
      bits_left <= '0;
      shreg     <= '0;
      rx        <= '0;
      rdata     <= '0;
      cs_n      <= '1;
    end else begin
      rd_q <= rd_req;
      wr_q <= wr_req;
      if (start) begin
        busy      <= 1'b1;
        phase     <= '0;
        is_read   <= ~wr_edge;
        cs_n      <= ~(NUM_CS'(1) << (dev_sel - 8'd1));
        if (wr_edge) begin
          shreg     <= {addr, wdata};
          bits_left <= BW'(SW);
        end else begin
          shreg     <= {1'b1, addr[AW-2:0], {DW{1'b0}}};
          bits_left <= BW'(RD_BITS);
        end
      end else if (busy) begin
        phase <= bit_end ? '0 : phase + 1'b1;
        if (phase == PH_SAMPLE)
          rx <= {rx[RW-2:0], miso};
        if (bit_end) begin
          shreg     <= {shreg[SW-2:0], 1'b0};
          bits_left <= bits_left - 1'b1;
          if (bits_left == BW'(1)) begin
            busy <= 1'b0;
            cs_n <= '1;
            if (is_read) rdata <= rx;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_multidev_host_chk.sv
module spi_multidev_host_chk #(
  parameter int NUM_CS = 6,
  parameter int RW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic [RW-1:0]     rdata
);

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_cs_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(cs_n));

  assert_sclk_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sclk);

  assert_idle_no_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (&cs_n));

  assert_start_selects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> !(&cs_n));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> $stable(rdata));

endmodule

bind spi_multidev_host spi_multidev_host_chk #(.NUM_CS(NUM_CS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .sclk(sclk), .cs_n(cs_n), .rdata(rdata)
);

// File: tb/spi_multidev_host_test.sv
`timescale 1ns/1ps
module spi_multidev_host_test;
  localparam int CLK_PERIOD = 25;
  localparam int DIV = 4;
  localparam int NCS = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] dev_sel = '0;
  logic [15:0] addr = '0, wdata = '0;
  logic rd_req = 1'b0, wr_req = 1'b0, miso = 1'b0;
  wire [7:0] rdata;
  wire idle, sclk, mosi;
  wire [NCS-1:0] cs_n;

  int errors = 0, checks = 0;
  int miso_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  spi_multidev_host #(.CLK_DIV(DIV), .NUM_CS(NCS)) uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr(addr), .wdata(wdata),
    .rd_req(rd_req), .wr_req(wr_req), .rdata(rdata), .idle(idle),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= (miso_mode == 1) ? 1'b1 : (miso_mode == 2) ? 1'b0 : lfsr[15];
  end

  bit m_busy = 0, m_read = 0, m_rdp = 0, m_wrp = 0;
  int m_cnt = 0, m_len = 0, m_dev = 1;
  logic [31:0] m_frame = '0;
  logic [7:0] m_rx = '0, m_rdata = '0;

  always @(posedge clk) begin : model
    bit re, we;
    if (!rst_n) begin
      m_busy = 0; m_rdp = 0; m_wrp = 0; m_rx = '0; m_rdata = '0;
    end else begin
      re = rd_req && !m_rdp;
      we = wr_req && !m_wrp;
      if (m_busy) begin
        if (m_cnt % DIV == DIV/2 - 1) m_rx = {m_rx[6:0], miso};
        if (m_cnt == m_len*DIV - 1) begin
          m_busy = 0;
          if (m_read) m_rdata = m_rx;
        end else m_cnt++;
      end else if ((re || we) && dev_sel >= 1 && dev_sel <= NCS) begin
        m_busy = 1; m_cnt = 0; m_read = !we; m_dev = dev_sel;
        m_len = we ? 32 : 24;
        m_frame = we ? {addr, wdata} : {1'b1, addr[14:0], 16'h0000};
      end
      m_rdp = rd_req; m_wrp = wr_req;
    end
  end

  always @(negedge clk) begin : compare
    logic [NCS-1:0] exp_cs;
    bit exp_sclk;
    if (rst_n) begin
      chk(idle == !m_busy, "R7", "idle", int'(idle), int'(!m_busy));
      exp_cs = m_busy ? ~(NCS'(1) << (m_dev - 1)) : '1;
      chk(cs_n == exp_cs, "R2", "cs_n", int'(cs_n), int'(exp_cs));
      exp_sclk = m_busy && (m_cnt % DIV >= DIV/2);
      chk(sclk == exp_sclk, "R6", "sclk", int'(sclk), int'(exp_sclk));
      if (m_busy)
        chk(mosi == m_frame[31 - m_cnt/DIV], m_read ? "R5" : "R4", "mosi",
            int'(mosi), int'(m_frame[31 - m_cnt/DIV]));
      chk(rdata == m_rdata, "R10", "rdata", int'(rdata), int'(m_rdata));
    end
  end

  task automatic wait_idle(output int lowcyc);
    lowcyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (idle) break;
      lowcyc++;
    end
  endtask

  task automatic access(input int code, input int a, input int d, input bit r,
                        input bit w, input int mm, output int lowcyc);
    @(negedge clk);
    dev_sel = 8'(code); addr = 16'(a); wdata = 16'(d); miso_mode = mm;
    rd_req = r; wr_req = w;
    wait_idle(lowcyc);
    rd_req = 0; wr_req = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    int lc;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R1", "reset idle", int'(idle), 1);
    chk(cs_n == '1, "R1", "reset cs_n", int'(cs_n), 'h3f);
    chk(sclk == 1'b0, "R1", "reset sclk", int'(sclk), 0);
    chk(rdata == 8'h00, "R1", "reset rdata", int'(rdata), 0);
    rst_n = 1'b1;

    access(1, 'hA55A, 'h1234, 0, 1, 0, lc);
    chk(lc == 32*DIV, "R4", "write length", lc, 32*DIV);

    access(2, 'h0F0F, 0, 1, 0, 1, lc);
    chk(lc == 24*DIV, "R5", "read length", lc, 24*DIV);
    chk(rdata == 8'hFF, "R5", "read ones", int'(rdata), 'hff);

    access(3, 'h7FFF, 0, 1, 0, 2, lc);
    chk(rdata == 8'h00, "R5", "read zeros", int'(rdata), 0);

    for (int k = 1; k <= NCS; k++) begin
      access(k, 'h1111 * k, 'hFFFF - k, 0, 1, 0, lc);
      access(k, 'h8000 | k, 0, 1, 0, 0, lc);
    end

    access(4, 'h00FF, 0, 1, 0, 1, lc);
    keep = rdata;
    access(4, 'h1357, 'h2468, 0, 1, 0, lc);
    chk(rdata == keep, "R10", "write keeps rdata", int'(rdata), int'(keep));

    access(0, 'h1234, 'h5678, 1, 0, 2, lc);
    chk(lc == 0, "R8", "code 0 no frame", lc, 0);
    access(7, 'h1234, 'h5678, 1, 0, 2, lc);
    chk(lc == 0, "R8", "code 7 no frame", lc, 0);
    access(255, 'h1234, 'h5678, 0, 1, 2, lc);
    chk(lc == 0, "R8", "code 255 no frame", lc, 0);
    chk(rdata == keep, "R8", "invalid keeps rdata", int'(rdata), int'(keep));

    access(5, 'h4321, 'h8765, 1, 1, 2, lc);
    chk(lc == 32*DIV, "R9", "write wins length", lc, 32*DIV);
    chk(rdata == keep, "R9", "write wins rdata", int'(rdata), int'(keep));

    @(negedge clk);
    dev_sel = 8'd6; addr = 16'hBEEF; wdata = 16'hCAFE; miso_mode = 2;
    wr_req = 1;
    repeat (10) @(negedge clk);
    rd_req = 1;
    wait_idle(lc);
    wr_req = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(idle == 1'b1, "R7", "busy edge dropped", int'(idle), 1);
    end
    chk(rdata == keep, "R7", "busy edge no read", int'(rdata), int'(keep));
    rd_req = 0;

    @(negedge clk);
    dev_sel = 8'd2; wr_req = 1; miso_mode = 0;
    wait_idle(lc);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(idle == 1'b1, "R3", "held level no restart", int'(idle), 1);
    end
    wr_req = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule